// File: doc/BRIEF.md
# Interrupt File Indirect Array Access Port

This block holds the per-identity pending and enable bits of one or more interrupt files. It serves the indirect register-select accesses that a hart makes to that state. Each request carries a select number, the requesting privilege mode, a virtualization flag, a guest-file selector, a register width of 32 or 64 bits, a new value and a write mask. The block checks the privilege against the level the instance is built for, picks the target file, and turns the select number into a word of the pending array or of the enable array. It then returns the old contents of that word and performs a masked read-modify-write on it in the same access.

A request is taken in one cycle and its response comes back in the next cycle. An access that cannot be served raises the error flag for that response cycle, returns zero and changes no state. Choosing the highest-priority interrupt and the message-write path belong to other blocks.

Top module: `irq_file_access`

## Requirements
- R1: Selects `PEND_BASE` to `PEND_BASE+63` address the pending array and selects `EN_BASE` to `EN_BASE+63` address the enable array. The raw register index is the select minus the group base. Any other select is an error. The defaults are 0x080 and 0x0C0.
- R2: With `wide_i`=1 (64-bit), an odd raw index is an error and an even raw index is halved to give the word index. With `wide_i`=0 (32-bit), the raw index is the word index.
- R3: A word index at or above `NUM_IDS/width` is an error. For 128 identities that bound is 4 in 32-bit mode and 2 in 64-bit mode.
- R4: Read data bit i is the pending bit or enable bit of identity (word index × width + i), taken before the write of the same access. In 32-bit mode, bits 63:32 read zero.
- R5: Only identities in the addressed slice whose write-mask bit is 1 are updated, each to the matching bit of the new value. In 32-bit mode, mask bits 63:32 have no effect.
- R6: Identity 0 (bit 0 of word 0) of both arrays in every file reads zero and ignores writes.
- R7: A machine-level instance (`MACHINE_LEVEL`=1) accepts only accesses with `priv_i`=2'b11 and `virt_i`=0, and serves them from file 0. All other accesses are errors.
- R8: A supervisor-level instance accepts only accesses with `priv_i`=2'b01. If `virt_i`=0 the target is file 0. If `virt_i`=1 the target is file `gsel_i`, which must be nonzero and below `NUM_FILES`, or the access is an error. Privilege encodings: 2'b00 user, 2'b01 supervisor, 2'b11 machine.
- R9: An erroring access changes no state, returns `rdata_o`=0 and raises `err_o` for its single response cycle.
- R10: `resp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. `err_o` is low whenever `resp_valid_o` is low.
- R11: After reset, every pending bit and every enable bit is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| sel_i | input | SEL_W | Register select number |
| priv_i | input | 2 | Requesting privilege mode |
| virt_i | input | 1 | Access comes from a virtualized context |
| gsel_i | input | GSEL_W | Guest-file selector |
| wide_i | input | 1 | 1 = 64-bit register width, 0 = 32-bit |
| wdata_i | input | 64 | New value |
| wmask_i | input | 64 | Write mask, 1 = update bit |
| resp_valid_o | output | 1 | Response for the previous cycle's request |
| rdata_o | output | 64 | Old contents of the addressed word |
| err_o | output | 1 | Access was rejected |

## Verification
The bench goes after the word bounds. Index 3 must work while index 4 fails in 32-bit mode, and select base+2 must work while base+4 fails in 64-bit mode. A design that got the bound or the halving wrong would either write past the array or reject a legal word. Odd selects in 64-bit mode must fail. The guest selector is probed at 0, at the last legal file and at the file count. A design that is off by one there would let a guest reach file 0 or a file that does not exist. Identity 0 is written with all ones, and errored writes are followed by read-backs, so that a leaking hardwired bit or a write that lands despite the error shows up at the read port.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned GROUP_REGS = 64;
  localparam int unsigned DATA_W     = 64;
endpackage

// File: rtl/ifa_file_sel.sv
module ifa_file_sel
  import ifa_pkg::*;
#(
  parameter int unsigned NUM_FILES     = 4,
  parameter bit          MACHINE_LEVEL = 1'b0,
  parameter int unsigned GSEL_W        = 6,
  localparam int unsigned FILE_W       = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [GSEL_W-1:0] gsel_i,
  output logic [FILE_W-1:0] file_o,
  output logic              err_o
);
  generate
    if (MACHINE_LEVEL) begin : g_mlevel
      assign file_o = '0;
      assign err_o  = !(priv_i == PRIV_M && !virt_i);
    end else begin : g_slevel
      always_comb begin
        file_o = '0;
        err_o  = 1'b1;
        if (priv_i == PRIV_S) begin
          if (!virt_i) begin
            err_o = 1'b0;
          end else if (gsel_i != '0 && gsel_i < GSEL_W'(NUM_FILES)) begin
            err_o  = 1'b0;
            file_o = FILE_W'(gsel_i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ifa_reg_decode.sv
module ifa_reg_decode #(
  parameter int unsigned NUM_IDS   = 128,
  parameter int unsigned SEL_W     = 12,
  parameter int unsigned PEND_BASE = 'h080,
  parameter int unsigned EN_BASE   = 'h0C0,
  localparam int unsigned ID_W     = $clog2(NUM_IDS),
  localparam int unsigned LIM32    = NUM_IDS / 32,
  localparam int unsigned LIM64    = NUM_IDS / 64
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wide_i,
  output logic             is_pend_o,
  output logic [ID_W-1:0]  base_o,
  output logic             err_o
);
  logic       in_pend, in_en;
  logic [5:0] raw_idx, word_idx;

  assign in_pend = (sel_i >= SEL_W'(PEND_BASE)) && (sel_i < SEL_W'(PEND_BASE + 64));
  assign in_en   = (sel_i >= SEL_W'(EN_BASE))   && (sel_i < SEL_W'(EN_BASE + 64));

  always_comb begin
    logic [SEL_W-1:0] off;
    off       = in_pend ? (sel_i - SEL_W'(PEND_BASE)) : (sel_i - SEL_W'(EN_BASE));
    raw_idx   = off[5:0];
    is_pend_o = in_pend;
  end

  assign word_idx = wide_i ? {1'b0, raw_idx[5:1]} : raw_idx;
  assign base_o   = wide_i ? (ID_W'(word_idx) << 6) : (ID_W'(word_idx) << 5);

  always_comb begin
    err_o = 1'b0;
    if (!(in_pend || in_en))                                  err_o = 1'b1;
    if (wide_i && raw_idx[0])                                 err_o = 1'b1;
    if (32'(word_idx) >= (wide_i ? LIM64 : LIM32))            err_o = 1'b1;
  end
endmodule

// File: rtl/ifa_state_array.sv
module ifa_state_array #(
  parameter int unsigned NUM_IDS   = 128,
  parameter int unsigned NUM_FILES = 4,
  localparam int unsigned ID_W     = $clog2(NUM_IDS),
  localparam int unsigned FILE_W   = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [FILE_W-1:0]              file_i,
  input  logic                           is_pend_i,
  input  logic [ID_W-1:0]                base_i,
  input  logic [63:0]                    wdata_i,
  input  logic [63:0]                    wmask_i,
  output logic [NUM_FILES*NUM_IDS-1:0]   pend_all_o,
  output logic [NUM_FILES*NUM_IDS-1:0]   en_all_o
);
  logic [NUM_IDS-1:0] hit, val;

  // expand the 64-bit slice mask/value onto identity positions
  always_comb begin
    for (int id = 0; id < NUM_IDS; id++) begin
      logic [ID_W-1:0] off;
      off     = ID_W'(id) - base_i;
      hit[id] = (ID_W'(id) >= base_i) && (32'(off) < 64) && wmask_i[off[5:0]];
      val[id] = wdata_i[off[5:0]];
    end
  end

  generate
    for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
      logic [NUM_IDS-1:0] pend_q, en_q;
      logic               sel_f;
      assign sel_f = we_i && (file_i == FILE_W'(f));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= '0;
          en_q   <= '0;
        end else if (sel_f) begin
          if (is_pend_i) pend_q <= (pend_q & ~hit) | (val & hit);
          else           en_q   <= (en_q & ~hit) | (val & hit);
        end
      end
      assign pend_all_o[f*NUM_IDS +: NUM_IDS] = pend_q;
      assign en_all_o[f*NUM_IDS +: NUM_IDS]   = en_q;
    end
  endgenerate
endmodule

// File: rtl/irq_file_access.sv
module irq_file_access
  import ifa_pkg::*;
#(
  parameter int unsigned NUM_IDS       = 128,
  parameter int unsigned NUM_FILES     = 4,
  parameter bit          MACHINE_LEVEL = 1'b0,
  parameter int unsigned SEL_W         = 12,
  parameter int unsigned GSEL_W        = 6,
  parameter int unsigned PEND_BASE     = 'h080,
  parameter int unsigned EN_BASE       = 'h0C0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [GSEL_W-1:0] gsel_i,
  input  logic              wide_i,
  input  logic [63:0]       wdata_i,
  input  logic [63:0]       wmask_i,
  output logic              resp_valid_o,
  output logic [63:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned ID_W   = $clog2(NUM_IDS);
  localparam int unsigned FILE_W = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1;

  logic [FILE_W-1:0]            file_idx;
  logic                         file_err, reg_err, acc_err, is_pend, we;
  logic [ID_W-1:0]              base;
  logic [63:0]                  width_mask, eff_mask, rd_slice;
  logic [NUM_IDS-1:0]           rd_vec;
  logic [NUM_FILES*NUM_IDS-1:0] pend_all, en_all;

  ifa_file_sel #(
    .NUM_FILES(NUM_FILES), .MACHINE_LEVEL(MACHINE_LEVEL), .GSEL_W(GSEL_W)
  ) u_file_sel (
    .priv_i(priv_i), .virt_i(virt_i), .gsel_i(gsel_i),
    .file_o(file_idx), .err_o(file_err)
  );

  ifa_reg_decode #(
    .NUM_IDS(NUM_IDS), .SEL_W(SEL_W), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE)
  ) u_decode (
    .sel_i(sel_i), .wide_i(wide_i),
    .is_pend_o(is_pend), .base_o(base), .err_o(reg_err)
  );

  assign acc_err    = file_err | reg_err;
  assign we         = req_valid_i & ~acc_err;
  assign width_mask = wide_i ? '1 : 64'h0000_0000_FFFF_FFFF;
  // identity 0 is hardwired: drop mask bit 0 on the first word
  assign eff_mask   = wmask_i & width_mask & ((base == '0) ? ~64'd1 : '1);

  ifa_state_array #(
    .NUM_IDS(NUM_IDS), .NUM_FILES(NUM_FILES)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .file_i(file_idx),
    .is_pend_i(is_pend), .base_i(base), .wdata_i(wdata_i), .wmask_i(eff_mask),
    .pend_all_o(pend_all), .en_all_o(en_all)
  );

  always_comb begin
    rd_vec = '0;
    for (int f = 0; f < NUM_FILES; f++) begin
      if (file_idx == FILE_W'(f))
        rd_vec = is_pend ? pend_all[f*NUM_IDS +: NUM_IDS] : en_all[f*NUM_IDS +: NUM_IDS];
    end
  end

  always_comb begin
    for (int i = 0; i < 64; i++) begin
      logic [ID_W:0] k;
      k           = {1'b0, base} + (ID_W+1)'(i);
      rd_slice[i] = (32'(k) < NUM_IDS) ? rd_vec[k[ID_W-1:0]] : 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      err_o        <= 1'b0;
      rdata_o      <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      err_o        <= req_valid_i & acc_err;
      rdata_o      <= we ? (rd_slice & width_mask) : '0;
    end
  end
endmodule

// File: rtl/ifa_checker.sv
module ifa_checker
  import ifa_pkg::*;
#(
  parameter int unsigned NUM_IDS       = 128,
  parameter int unsigned NUM_FILES     = 4,
  parameter bit          MACHINE_LEVEL = 1'b0,
  parameter int unsigned SEL_W         = 12,
  parameter int unsigned PEND_BASE     = 'h080
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic [SEL_W-1:0]             sel_i,
  input logic [1:0]                   priv_i,
  input logic                         wide_i,
  input logic                         resp_valid_o,
  input logic [63:0]                  rdata_o,
  input logic                         err_o,
  input logic [NUM_FILES*NUM_IDS-1:0] pend_all_i,
  input logic [NUM_FILES*NUM_IDS-1:0] en_all_i
);
  logic [NUM_FILES-1:0] id0_bits;
  always_comb
    for (int f = 0; f < NUM_FILES; f++)
      id0_bits[f] = pend_all_i[f*NUM_IDS] | en_all_i[f*NUM_IDS];

  assert_resp_timing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && !err_o));
  assert_err_zero_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  assert_user_keeps_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i == PRIV_U) |=> (err_o && $stable(pend_all_i) && $stable(en_all_i)));
  assert_odd_wide_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && wide_i && sel_i == SEL_W'(PEND_BASE + 1)) |=> err_o);
  // covers R7 for machine-level builds
  assert_wrong_priv_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (MACHINE_LEVEL ? (priv_i != PRIV_M) : (priv_i != PRIV_S))) |=> err_o);
  assert_narrow_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !$past(wide_i)) |-> (rdata_o[63:32] == '0));
  assert_id0_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id0_bits == '0);
endmodule

bind irq_file_access ifa_checker #(
  .NUM_IDS(NUM_IDS), .NUM_FILES(NUM_FILES), .MACHINE_LEVEL(MACHINE_LEVEL),
  .SEL_W(SEL_W), .PEND_BASE(PEND_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .sel_i(sel_i),
  .priv_i(priv_i), .wide_i(wide_i), .resp_valid_o(resp_valid_o),
  .rdata_o(rdata_o), .err_o(err_o), .pend_all_i(pend_all), .en_all_i(en_all)
);

// File: tb/irq_file_access_test.sv
module irq_file_access_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIDS = 128;
  localparam int NF   = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, virt = 1'b0, wide = 1'b0;
  logic [11:0] sel = '0;
  logic [1:0]  priv = '0;
  logic [5:0]  gsel = '0;
  logic [63:0] wdata = '0, wmask = '0;
  logic        s_rv, s_err, m_rv, m_err;
  logic [63:0] s_rd, m_rd;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [NIDS-1:0] s_pend [NF];
  logic [NIDS-1:0] s_en   [NF];
  logic [NIDS-1:0] m_pend, m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_file_access #(.NUM_IDS(NIDS), .NUM_FILES(NF), .MACHINE_LEVEL(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .sel_i(sel), .priv_i(priv),
    .virt_i(virt), .gsel_i(gsel), .wide_i(wide), .wdata_i(wdata), .wmask_i(wmask),
    .resp_valid_o(s_rv), .rdata_o(s_rd), .err_o(s_err));

  irq_file_access #(.NUM_IDS(NIDS), .NUM_FILES(1), .MACHINE_LEVEL(1'b1)) uut_m (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .sel_i(sel), .priv_i(priv),
    .virt_i(virt), .gsel_i(gsel), .wide_i(wide), .wdata_i(wdata), .wmask_i(wmask),
    .resp_valid_o(m_rv), .rdata_o(m_rd), .err_o(m_err));

  function automatic void ref_decode(input bit ml, input int nf, input logic [11:0] sl,
      input logic [1:0] pr, input bit vt, input logic [5:0] gs, input bit wd,
      output bit er, output int fi, output bit pd, output int base, output int w);
    int ri;
    er = 0; fi = 0; pd = 0; ri = 0;
    w = wd ? 64 : 32;
    if (ml) begin
      if (!(pr == 2'b11 && !vt)) er = 1;
    end else begin
      if (pr != 2'b01) er = 1;
      else if (vt) begin
        if (gs == 0 || int'(gs) >= nf) er = 1;
        else fi = int'(gs);
      end
    end
    if (sl >= 12'h080 && sl < 12'h0C0) begin pd = 1; ri = int'(sl) - 'h80; end
    else if (sl >= 12'h0C0 && sl < 12'h100) begin pd = 0; ri = int'(sl) - 'hC0; end
    else er = 1;
    if (wd) begin
      if (ri % 2 == 1) er = 1;
      ri = ri / 2;
    end
    if (ri >= NIDS / w) er = 1;
    base = ri * w;
  endfunction

  function automatic logic [63:0] ref_rmw(inout logic [NIDS-1:0] v, input int base,
      input int w, input logic [63:0] d, input logic [63:0] m);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) begin
      r[i] = v[base+i];
      if (m[i] && !(base == 0 && i == 0)) v[base+i] = d[i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input string who, input logic rv, input logic er,
      input logic [63:0] rd, input logic e_er, input logic [63:0] e_rd);
    checks++;
    if (rv !== 1'b1 || er !== e_er || rd !== e_rd) begin
      failures++;
      $display("FAIL %s %s: valid=%b err=%b rdata=%h expected valid=1 err=%b rdata=%h",
               tag, who, rv, er, rd, e_er, e_rd);
    end
  endtask

  task automatic access(input logic [11:0] sl, input logic [1:0] pr, input bit vt,
      input logic [5:0] gs, input bit wd, input logic [63:0] d, input logic [63:0] m,
      input string tag);
    bit er, pd; int fi, base, w;
    logic [63:0] se_rd, me_rd; bit se_er, me_er;
    sel = sl; priv = pr; virt = vt; gsel = gs; wide = wd; wdata = d; wmask = m; req = 1'b1;
    ref_decode(1'b0, NF, sl, pr, vt, gs, wd, er, fi, pd, base, w);
    se_er = er; se_rd = '0;
    if (!er) begin
      if (pd) se_rd = ref_rmw(s_pend[fi], base, w, d, m);
      else    se_rd = ref_rmw(s_en[fi], base, w, d, m);
    end
    ref_decode(1'b1, 1, sl, pr, vt, gs, wd, er, fi, pd, base, w);
    me_er = er; me_rd = '0;
    if (!er) begin
      if (pd) me_rd = ref_rmw(m_pend, base, w, d, m);
      else    me_rd = ref_rmw(m_en, base, w, d, m);
    end
    @(negedge clk);
    req = 1'b0;
    check(tag, "sfile", s_rv, s_err, s_rd, se_er, se_rd);
    check(tag, "mfile", m_rv, m_err, m_rd, me_er, me_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int f = 0; f < NF; f++) begin s_pend[f] = '0; s_en[f] = '0; end
    m_pend = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: outputs low and arrays empty after reset
    checks++;
    if (s_rv !== 0 || s_err !== 0 || s_rd !== 0 || m_rv !== 0 || m_rd !== 0) begin
      failures++;
      $display("FAIL R11 reset outputs: valid=%b err=%b rdata=%h expected 0 0 0", s_rv, s_err, s_rd);
    end
    access(12'h083, 2'b01, 0, 0, 0, '0, '0, "R11");
    access(12'h0C1, 2'b11, 0, 0, 1, '0, '0, "R11");
    // R5 masked write, R4 readback
    access(12'h081, 2'b01, 0, 0, 0, 64'hFFFF_FFFF_A5A5_A5A5, 64'hFFFF_FFFF_FFFF_0000, "R5");
    access(12'h081, 2'b01, 0, 0, 0, '0, '0, "R4");
    access(12'h082, 2'b01, 0, 0, 1, '0, '0, "R4");
    // R6 identity 0
    access(12'h080, 2'b01, 0, 0, 0, '1, '1, "R6");
    access(12'h080, 2'b01, 0, 0, 0, '0, '0, "R6");
    access(12'h0C0, 2'b11, 0, 0, 1, '1, '1, "R6");
    access(12'h0C0, 2'b11, 0, 0, 1, '0, '0, "R6");
    // R2 odd/even in wide mode
    access(12'h081, 2'b01, 0, 0, 1, '1, '1, "R2");
    access(12'h0C3, 2'b11, 0, 0, 1, '1, '1, "R2");
    access(12'h082, 2'b01, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, '1, "R2");
    access(12'h083, 2'b01, 0, 0, 0, '0, '0, "R2");
    // R3 bounds
    access(12'h083, 2'b01, 0, 0, 0, '1, 64'hF0F0, "R3");
    access(12'h084, 2'b01, 0, 0, 0, '1, '1, "R3");
    access(12'h084, 2'b01, 0, 0, 1, '1, '1, "R3");
    access(12'h0FF, 2'b01, 0, 0, 0, '1, '1, "R3");
    // R1 select map
    access(12'h07F, 2'b01, 0, 0, 0, '1, '1, "R1");
    access(12'h100, 2'b01, 0, 0, 0, '1, '1, "R1");
    access(12'h0C3, 2'b01, 0, 0, 0, '1, 64'h8000_0001, "R1");
    access(12'h083, 2'b01, 0, 0, 0, '0, '0, "R1");
    // R8 guest selection
    access(12'h081, 2'b01, 1, 0, 0, '1, '1, "R8");
    access(12'h081, 2'b01, 1, 3, 0, 64'hCAFE, '1, "R8");
    access(12'h081, 2'b01, 1, 3, 0, '0, '0, "R8");
    access(12'h081, 2'b01, 1, 4, 0, '1, '1, "R8");
    access(12'h081, 2'b01, 0, 3, 0, '0, '0, "R8");
    // R7 machine-level file
    access(12'h081, 2'b11, 1, 0, 0, '1, '1, "R7");
    access(12'h081, 2'b11, 0, 0, 0, 64'h55, '1, "R7");
    access(12'h081, 2'b11, 0, 0, 0, '0, '0, "R7");
    // R9 errored write leaves state
    access(12'h085, 2'b00, 0, 0, 0, '1, '1, "R9");
    access(12'h085, 2'b00, 0, 0, 0, '0, '0, "R9");
    access(12'h081, 2'b01, 0, 0, 0, '0, '0, "R9");
    // R10 idle cycle gives no response
    @(negedge clk);
    checks++;
    if (s_rv !== 0 || s_err !== 0 || m_rv !== 0) begin
      failures++;
      $display("FAIL R10 idle: valid=%b err=%b expected 0 0", s_rv, s_err);
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] sl; logic [1:0] pr; int r;
      r  = int'($urandom % 8);
      sl = (r < 4) ? 12'(12'h080 + ($urandom % 10))
         : (r < 7) ? 12'(12'h0C0 + ($urandom % 10)) : 12'($urandom);
      r  = int'($urandom % 8);
      pr = (r < 5) ? 2'b01 : (r < 7) ? 2'b11 : 2'b00;
      access(sl, pr, ($urandom % 4) == 0, 6'($urandom % 6), ($urandom % 2) == 1,
             {$urandom, $urandom}, {$urandom, $urandom}, "R4_R5");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule